// File: doc/BRIEF.md
# Framed Stereo Serial Sample Receiver

This block takes two serial bit streams, one per audio channel, that share a slow data clock (`dclk`) and a word-alignment pulse (`frame_in`). Both channels arrive at the same time on their own pins. The block samples every bit on the falling edge of `dclk` and builds one 16-bit word per channel, most significant bit first. It then hands the pair of words to the faster, unrelated system clock (`clk`). There the pair appears on `word_left` and `word_right` together with a single-cycle `word_valid` strobe and a per-channel all-zero flag. `in_ready` tells the controller that the receiver is out of reset and able to take samples. It changes only on a rising edge of `clk`.

In the data-clock domain a two-state controller runs the word:
- `FR_IDLE` waits for a frame pulse.
- `frame_in` moves it to `FR_SHIFT` and loads a bit count of one.
- `FR_SHIFT` returns to `FR_IDLE` when the sixteenth bit arrives. At that point the word is copied into a holding register and a toggle flag flips.
- A frame pulse seen in `FR_SHIFT` restarts the count, and the partial word is dropped. If that pulse falls where the sixteenth bit would be, the restart takes precedence over completing the word.

The toggle flag crosses into the system domain through two synchronizing flops, and an edge detector turns each flip into one event. The system-domain controller runs as follows:
- It starts in `SYS_RESET`, with `in_ready` low.
- On the first clock after reset it moves to `SYS_READY`.
- On an event it loads the held words and zero flags and moves to `SYS_DELIVER`, which drives `word_valid` for one cycle.
- It then returns to `SYS_READY`.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `rst_n` is low, `word_valid`, `in_ready`, `zero_left` and `zero_right` are 0 and `word_left`/`word_right` are 0.
- R2: `in_ready` becomes 1 at the first rising edge of `clk` after `rst_n` goes high and stays 1 while reset is released.
- R3: Serial bits are sampled on falling edges of `dclk`. The bit sampled on the edge where `frame_in` is 1 is bit 15 of the word, and the following 15 falling edges supply bits 14 down to 0.
- R4: The left and right words are assembled in parallel, each only from its own serial pin, within the same frame.
- R5: Each completed word produces exactly one `word_valid` pulse, one `clk` cycle wide. It goes high no later than the 4th rising edge of `clk` after the `dclk` falling edge that sampled bit 0. The output words hold their value between pulses.
- R6: `zero_left` (`zero_right`) is 1 exactly when the delivered left (right) word is 0x0000. It is updated together with the words.
- R7: A `frame_in` pulse before bit 0 of a word has been sampled (including on the 16th bit position) discards the partial word, produces no pulse, and starts a new word with that bit as bit 15.
- R8: Bits on `dclk` falling edges outside a framed word are ignored: no pulse occurs and the output words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dclk | input | 1 | Serial data clock, bits sampled on its falling edge |
| frame_in | input | 1 | One-`dclk`-period word alignment pulse |
| ser_left | input | 1 | Left channel serial data |
| ser_right | input | 1 | Right channel serial data |
| word_left | output | 16 | Last delivered left word |
| word_right | output | 16 | Last delivered right word |
| word_valid | output | 1 | One-cycle strobe when a new word pair is delivered |
| zero_left | output | 1 | Delivered left word is all zeros |
| zero_right | output | 1 | Delivered right word is all zeros |
| in_ready | output | 1 | Receiver can accept serial data |

## Verification
The collision that matters is a frame pulse on the same `dclk` falling edge that would otherwise complete a word. Restart and completion then compete in one cycle of `FR_SHIFT`. The bench sweeps partial words of every length from 1 to 15 bits, each followed directly by a new framed word, so the 15-bit case puts the new frame exactly on the completing edge. The bench judges each case by the count of `word_valid` pulses, which must rise by exactly one, and by whether the delivered words match the second word rather than any mix of the two.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic {
        FR_IDLE,
        FR_SHIFT
    } fr_state_t;

    typedef enum logic [1:0] {
        SYS_RESET,
        SYS_READY,
        SYS_DELIVER
    } sys_state_t;

endpackage

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
    import stereo_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic dclk,
    input  logic rst_n,
    input  logic frame_in,
    output logic shift_en,
    output logic word_done,
    output logic tgl
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    fr_state_t        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;

    // next state and count
    always_comb begin
        state_d   = state_q;
        bit_cnt_d = bit_cnt_q;
        unique case (state_q)
            FR_IDLE: begin
                if (frame_in) begin
                    state_d   = FR_SHIFT;
                    bit_cnt_d = CNT_W'(1);
                end
            end
            FR_SHIFT: begin
                if (frame_in) begin
                    bit_cnt_d = CNT_W'(1);
                end else if (bit_cnt_q == LAST_BIT) begin
                    state_d   = FR_IDLE;
                    bit_cnt_d = '0;
                end else begin
                    bit_cnt_d = bit_cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d   = FR_IDLE;
                bit_cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(negedge dclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= FR_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q   <= state_d;
            bit_cnt_q <= bit_cnt_d;
        end
    end

    // outputs
    always_comb begin
        shift_en  = frame_in || (state_q == FR_SHIFT);
        word_done = (state_q == FR_SHIFT) && !frame_in && (bit_cnt_q == LAST_BIT);
    end

    always_ff @(negedge dclk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else if (word_done) tgl <= ~tgl;
    end

    // R7
    frame_restart_chk: assert property (@(negedge dclk) disable iff (!rst_n)
        frame_in |=> (state_q == FR_SHIFT && bit_cnt_q == CNT_W'(1)));

    // R8
    idle_hold_chk: assert property (@(negedge dclk) disable iff (!rst_n)
        (state_q == FR_IDLE && !frame_in) |=> (state_q == FR_IDLE && $stable(tgl)));

    // R5
    done_toggle_chk: assert property (@(negedge dclk) disable iff (!rst_n)
        word_done |=> (tgl != $past(tgl) && state_q == FR_IDLE));

endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
    parameter int WORD_W = 16
) (
    input  logic              dclk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              shift_en,
    input  logic              capture,
    output logic [WORD_W-1:0] hold_word
);

    logic [WORD_W-2:0] sh_q;

    always_ff @(negedge dclk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            hold_word <= '0;
        end else begin
            if (shift_en) sh_q <= {sh_q[WORD_W-3:0], ser_in};
            if (capture)  hold_word <= {sh_q, ser_in};
        end
    end

endmodule

// File: rtl/cdc_toggle_sync.sv
module cdc_toggle_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);

    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl_in};
    end

    assign evt = sync_q[1] ^ sync_q[2];

    // R5
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/rx_sys_ctrl.sv
module rx_sys_ctrl
    import stereo_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt,
    input  logic [NUM_CH-1:0][WORD_W-1:0] hold_w,
    output logic [NUM_CH-1:0][WORD_W-1:0] words_q,
    output logic [NUM_CH-1:0]             zero_q,
    output logic                          valid,
    output logic                          in_ready
);

    sys_state_t state_q, state_d;
    logic       load;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYS_RESET:   state_d = SYS_READY;
            SYS_READY:   if (evt) state_d = SYS_DELIVER;
            SYS_DELIVER: state_d = evt ? SYS_DELIVER : SYS_READY;
            default:     state_d = SYS_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SYS_RESET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        valid    = (state_q == SYS_DELIVER);
        in_ready = (state_q != SYS_RESET);
        load     = evt && (state_q != SYS_RESET);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[c] <= '0;
                zero_q[c]  <= 1'b0;
            end else if (load) begin
                words_q[c] <= hold_w[c];
                zero_q[c]  <= (hold_w[c] == '0);
            end
        end

        // R6
        zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid |-> (zero_q[c] == (words_q[c] == '0)));
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5
    word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(words_q));

    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import stereo_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk,
    input  logic              frame_in,
    input  logic              ser_left,
    input  logic              ser_right,
    output logic [WORD_W-1:0] word_left,
    output logic [WORD_W-1:0] word_right,
    output logic              word_valid,
    output logic              zero_left,
    output logic              zero_right,
    output logic              in_ready
);

    logic                          shift_en;
    logic                          word_done;
    logic                          tgl;
    logic                          evt;
    logic [NUM_CH-1:0]             ser_bits;
    logic [NUM_CH-1:0][WORD_W-1:0] hold_w;
    logic [NUM_CH-1:0][WORD_W-1:0] words_q;
    logic [NUM_CH-1:0]             zero_q;

    assign ser_bits = {ser_right, ser_left};

    ser_frame_ctrl #(.WORD_W(WORD_W)) u_frame (
        .dclk      (dclk),
        .rst_n     (rst_n),
        .frame_in  (frame_in),
        .shift_en  (shift_en),
        .word_done (word_done),
        .tgl       (tgl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        ser_lane #(.WORD_W(WORD_W)) u_lane (
            .dclk      (dclk),
            .rst_n     (rst_n),
            .ser_in    (ser_bits[c]),
            .shift_en  (shift_en),
            .capture   (word_done),
            .hold_word (hold_w[c])
        );
    end

    cdc_toggle_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl_in (tgl),
        .evt    (evt)
    );

    rx_sys_ctrl #(.WORD_W(WORD_W)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .hold_w   (hold_w),
        .words_q  (words_q),
        .zero_q   (zero_q),
        .valid    (word_valid),
        .in_ready (in_ready)
    );

    assign word_left  = words_q[0];
    assign word_right = words_q[1];
    assign zero_left  = zero_q[0];
    assign zero_right = zero_q[1];

endmodule

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dclk = 1'b1;
    logic        frame_in = 1'b0;
    logic        ser_left = 1'b0;
    logic        ser_right = 1'b0;
    logic [15:0] word_left, word_right;
    logic        word_valid, zero_left, zero_right, in_ready;

    int checks = 0;
    int errors = 0;
    int n_valid = 0;

    stereo_serial_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dclk       (dclk),
        .frame_in   (frame_in),
        .ser_left   (ser_left),
        .ser_right  (ser_right),
        .word_left  (word_left),
        .word_right (word_right),
        .word_valid (word_valid),
        .zero_left  (zero_left),
        .zero_right (zero_right),
        .in_ready   (in_ready)
    );

    always #5 clk = ~clk;

    initial begin
        #2;
        forever #40 dclk = ~dclk;
    end

    always @(posedge clk) if (word_valid) n_valid++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic f, input logic l, input logic r);
        @(posedge dclk);
        #1;
        frame_in  = f;
        ser_left  = l;
        ser_right = r;
    endtask

    task automatic send_bits(input logic [15:0] l, input logic [15:0] r, input int nbits);
        for (int i = 0; i < nbits; i++) drive_bit(i == 0, l[15-i], r[15-i]);
        @(negedge dclk);
        #1;
        frame_in = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] l, input logic [15:0] r);
        int  base;
        int  k;
        bit  seen;
        base = n_valid;
        k    = 0;
        seen = 0;
        send_bits(l, r, 16);
        for (int j = 1; j <= 6 && !seen; j++) begin
            @(negedge clk);
            if (word_valid) begin
                seen = 1;
                k    = j;
            end
        end
        check(seen && k <= 4, "R5 latency", k, 4);
        check(word_left == l, "R3 left word", word_left, l);
        check(word_right == r, "R4 right word", word_right, r);
        check(zero_left == (l == 16'h0), "R6 zero_left", zero_left, l == 16'h0);
        check(zero_right == (r == 16'h0), "R6 zero_right", zero_right, r == 16'h0);
        @(negedge clk);
        check(!word_valid, "R5 one-cycle pulse", word_valid, 0);
        check(n_valid == base + 1, "R5 pulse count", n_valid - base, 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] pl, pr;
        int          base;
        repeat (3) @(negedge clk);
        check(!word_valid, "R1 valid in reset", word_valid, 0);
        check(!in_ready, "R1 in_ready in reset", in_ready, 0);
        check(word_left == 0 && word_right == 0, "R1 words in reset", {word_left, word_right}, 0);
        check(!zero_left && !zero_right, "R1 zero flags in reset", {zero_left, zero_right}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R2 in_ready after reset", in_ready, 1);

        // corner words
        send_word(16'h0000, 16'h0000);
        send_word(16'h0000, 16'hFFFF);
        send_word(16'hFFFF, 16'h0000);
        send_word(16'h8000, 16'h0001);

        // walking one / walking zero sweep
        for (int i = 0; i < 16; i++) send_word(16'h1 << i, ~(16'h1 << i));

        // arithmetic patterns
        for (int i = 0; i < 8; i++) begin
            pl = 16'(i * 16'h2469 + 16'h0101);
            pr = 16'(pl * 16'h0005) ^ 16'h5A5A;
            send_word(pl, pr);
        end

        // R7 restart sweep: partial of every length, then a new word
        for (int p = 1; p <= 15; p++) begin
            base = n_valid;
            send_bits(16'hDEAD, 16'hBEEF, p);
            pl = 16'(16'h3C00 + p);
            pr = 16'(16'hC300 - p);
            send_word(pl, pr);
            check(n_valid == base + 1, "R7 partial discarded", n_valid - base, 1);
            check(word_left == pl && word_right == pr, "R7 restart word",
                  {word_left, word_right}, {pl, pr});
        end

        // R8 unframed bits ignored
        base = n_valid;
        pl = word_left;
        pr = word_right;
        for (int i = 0; i < 20; i++) drive_bit(1'b0, i[0], ~i[1]);
        repeat (10) @(negedge clk);
        check(n_valid == base, "R8 no pulse without frame", n_valid - base, 0);
        check(word_left == pl && word_right == pr, "R8 words unchanged",
              {word_left, word_right}, {pl, pr});

        check(in_ready, "R2 in_ready stays high", in_ready, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule